// File: doc/BRIEF.md
# Rotating Execution-Pipe Selector with Member Groups

This block arbitrates a processor resource group built from several member resources, each of which owns a small set of execution pipes. Every pipe and every member is one bit of a one-hot mask. When a request arrives, the group picks a member in rotating order and that member picks one of its own pipes, also in rotating order. Members with no free pipe and pipes that are busy are stepped over. The grant comes back in the same cycle as a pair of one-hot vectors: the member and the pipe within it.

Pipes are marked busy and free again through separate use and release inputs. When the last free pipe of a member is taken, the group drops that member from its current rotation. If the dropped member lies above the group's current candidate, it is also remembered, so that the next refill of the rotation leaves it out once. This stops a member that keeps becoming unavailable from winning ahead of its turn. A member that is released becomes selectable again, but it rejoins the rotation only at a refill.

Each rotation keeps a pending mask. The candidate is its highest set bit that is also ready. A selection clears the granted bit and every bit above it. When the pending mask holds no ready bit, it is refilled first from the full mask XOR the remembered set. The remembered set is then cleared. A pending mask that empties after any update refills the same way.

Top module: `pipe_rotor_top`

## Requirements
- R1: After synchronous active-high reset, every pipe is free, `ready` is 1, and both rotations hold their full masks. The first request therefore grants the highest member bit and its highest pipe bit.
- R2: Successive requests walk members from the highest bit downward and then wrap. Within a member, successive grants to that member walk its pipes from the highest bit downward and then wrap.
- R3: While `sel_req` is 1, `sel_member` and `sel_pipe` are each exactly one-hot. The pipe granted is never one that is marked busy. A pending candidate that is busy is stepped over.
- R4: `ready` is 1 exactly when at least one pipe of any member is free. `sel_req` may be raised only while `ready` is 1.
- R5: While `sel_req` is 0, `sel_member` and `sel_pipe` are zero. A `use_vld` cycle, with one-hot `use_member` and `use_pipe`, marks that pipe busy from the next cycle.
- R6: A member whose last free pipe is taken leaves the group's pending rotation and is not granted until a refill.
- R7: A member removed while its bit is above the group's current candidate (the highest pending bit) is left out of the next refill. It returns at the refill after that.
- R8: A member removed at or below the current candidate is not remembered, so the next refill includes it. A member in the pending mask with no free pipe is stepped over by a request.
- R9: A `rel_vld` cycle frees the pipe named by `rel_member` and `rel_pipe`. A member freed this way becomes ready again but is granted only after the group rotation refills.
- R10: A request and a release of a different pipe in the same cycle both take effect. So do a use and a release of different pipes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_req | input | 1 | Request one pipe this cycle |
| sel_member | output | NUM_RES | One-hot member granted (zero without a request) |
| sel_pipe | output | NUM_PIPES | One-hot pipe granted within that member |
| use_vld | input | 1 | Mark a pipe busy |
| use_member | input | NUM_RES | One-hot member of the pipe being marked busy |
| use_pipe | input | NUM_PIPES | One-hot pipe being marked busy |
| rel_vld | input | 1 | Free a pipe |
| rel_member | input | NUM_RES | One-hot member of the pipe being freed |
| rel_pipe | input | NUM_PIPES | One-hot pipe being freed |
| ready | output | 1 | At least one pipe is free |

## Verification
The assertions watch the properties that must hold in every cycle. These are the one-hot shape of grants under a request, the silent outputs without one, legal one-hot use strobes, requests only while ready, and readiness right after a release. What the properties cannot see is the order of fairness. Skipped busy pipes, members dropped from the rotation, the remembered set delaying a member by exactly one refill, and same-cycle select-with-release only show up in the bench's scripted sequence of grants.

// File: rtl/rotor_pkg.sv
package rotor_pkg;

    // Widest mask any rotation instance may use.
    localparam int MAX_W = 16;

    typedef logic [MAX_W-1:0] rmask_t;

    // Rotation state: bits still pending in this round, and members
    // pulled out ahead of the candidate that skip the next refill.
    typedef struct packed {
        rmask_t pend;
        rmask_t held;
    } rot_state_t;

    typedef struct packed {
        rot_state_t st;
        rmask_t     grant;
    } rot_step_t;

    function automatic rmask_t full_mask(int w);
        rmask_t m;
        m = '0;
        for (int i = 0; i < MAX_W; i++)
            if (i < w) m[i] = 1'b1;
        return m;
    endfunction

    function automatic rmask_t top_bit(rmask_t m);
        rmask_t r;
        r = '0;
        for (int i = 0; i < MAX_W; i++)
            if (m[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        return r;
    endfunction

    function automatic rot_state_t refill(rot_state_t s, rmask_t full);
        rot_state_t w;
        w = s;
        if (w.pend == '0) begin
            w.pend = full ^ w.held;
            w.held = '0;
        end
        return w;
    endfunction

    // One cycle of a rotation: optional advance, then optional removal.
    function automatic rot_step_t rot_step(rot_state_t s, rmask_t full,
                                           rmask_t rdy, logic adv,
                                           logic rm_vld, rmask_t rm_id);
        rot_step_t  o;
        rot_state_t w;
        rmask_t     hit;
        rmask_t     cur;
        w       = s;
        o.grant = '0;
        if (adv) begin
            hit = w.pend & rdy;
            if (hit == '0) begin
                w.pend = full ^ w.held;
                w.held = '0;
                hit    = w.pend & rdy;
            end
            o.grant = top_bit(hit);
            if (o.grant != '0)
                w.pend = w.pend & (o.grant - rmask_t'(1));
            w = refill(w, full);
        end
        if (rm_vld) begin
            cur = top_bit(w.pend);
            if (rm_id > cur)
                w.held = w.held | rm_id;
            w.pend = w.pend & ~rm_id;
            w = refill(w, full);
        end
        o.st = w;
        return o;
    endfunction

endpackage

// File: rtl/rr_rotor.sv
module rr_rotor #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] rdy,
    input  logic         rm_vld,
    input  logic [W-1:0] rm_id,
    output logic [W-1:0] grant
);
    import rotor_pkg::*;

    localparam rmask_t FULL = full_mask(W);

    rot_state_t state_q;
    rot_step_t  step;

    always_comb begin
        step  = rot_step(state_q, FULL, rmask_t'(rdy), adv, rm_vld, rmask_t'(rm_id));
        grant = step.grant[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.pend <= FULL;
            state_q.held <= '0;
        end else begin
            state_q <= step.st;
        end
    end
endmodule

// File: rtl/pipe_unit.sv
module pipe_unit #(
    parameter int P = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         use_hit,
    input  logic [P-1:0] use_pipe,
    input  logic         rel_hit,
    input  logic [P-1:0] rel_pipe,
    output logic [P-1:0] grant,
    output logic         any_free,
    output logic         drained
);
    logic [P-1:0] free_q;
    logic [P-1:0] free_n;

    always_comb begin
        free_n = free_q;
        if (rel_hit) free_n = free_n | rel_pipe;
        if (use_hit) free_n = free_n & ~use_pipe;
        drained  = use_hit && (free_n == '0);
        any_free = |free_q;
    end

    always_ff @(posedge clk) begin
        if (rst) free_q <= '1;
        else     free_q <= free_n;
    end

    rr_rotor #(.W(P)) u_rot (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .rdy    (free_q),
        .rm_vld (1'b0),
        .rm_id  ({P{1'b0}}),
        .grant  (grant)
    );
endmodule

// File: rtl/pipe_rotor_top.sv
module pipe_rotor_top #(
    parameter int NUM_RES   = 4,
    parameter int NUM_PIPES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_req,
    output logic [NUM_RES-1:0]   sel_member,
    output logic [NUM_PIPES-1:0] sel_pipe,
    input  logic                 use_vld,
    input  logic [NUM_RES-1:0]   use_member,
    input  logic [NUM_PIPES-1:0] use_pipe,
    input  logic                 rel_vld,
    input  logic [NUM_RES-1:0]   rel_member,
    input  logic [NUM_PIPES-1:0] rel_pipe,
    output logic                 ready
);
    logic [NUM_RES-1:0]   unit_free;
    logic [NUM_RES-1:0]   unit_drained;
    logic [NUM_RES-1:0]   grp_grant;
    logic [NUM_PIPES-1:0] unit_grant [NUM_RES];

    for (genvar g = 0; g < NUM_RES; g++) begin : g_unit
        pipe_unit #(.P(NUM_PIPES)) u_unit (
            .clk      (clk),
            .rst      (rst),
            .adv      (sel_req & grp_grant[g]),
            .use_hit  (use_vld & use_member[g]),
            .use_pipe (use_pipe),
            .rel_hit  (rel_vld & rel_member[g]),
            .rel_pipe (rel_pipe),
            .grant    (unit_grant[g]),
            .any_free (unit_free[g]),
            .drained  (unit_drained[g])
        );
    end

    rr_rotor #(.W(NUM_RES)) u_group (
        .clk    (clk),
        .rst    (rst),
        .adv    (sel_req),
        .rdy    (unit_free),
        .rm_vld (|unit_drained),
        .rm_id  (unit_drained),
        .grant  (grp_grant)
    );

    always_comb begin
        sel_pipe = '0;
        for (int i = 0; i < NUM_RES; i++)
            sel_pipe = sel_pipe | unit_grant[i];
        sel_member = grp_grant;
        ready      = |unit_free;
    end
endmodule

// File: rtl/pipe_rotor_chk.sv
module pipe_rotor_chk #(
    parameter int NUM_RES   = 4,
    parameter int NUM_PIPES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sel_req,
    input logic [NUM_RES-1:0]   sel_member,
    input logic [NUM_PIPES-1:0] sel_pipe,
    input logic                 use_vld,
    input logic [NUM_RES-1:0]   use_member,
    input logic [NUM_PIPES-1:0] use_pipe,
    input logic                 rel_vld,
    input logic                 ready
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        sel_req |-> ($countones(sel_member) == 1 && $countones(sel_pipe) == 1)); // R3

    AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        sel_req |-> ready); // R4

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !sel_req |-> (sel_member == '0 && sel_pipe == '0)); // R5

    AST_USE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        use_vld |-> ($countones(use_member) == 1 && $countones(use_pipe) == 1)); // R5

    AST_READY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rel_vld |=> ready); // R9
endmodule

bind pipe_rotor_top pipe_rotor_chk #(
    .NUM_RES   (NUM_RES),
    .NUM_PIPES (NUM_PIPES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_req    (sel_req),
    .sel_member (sel_member),
    .sel_pipe   (sel_pipe),
    .use_vld    (use_vld),
    .use_member (use_member),
    .use_pipe   (use_pipe),
    .rel_vld    (rel_vld),
    .ready      (ready)
);

// File: tb/tb_pipe_rotor_top.sv
module tb_pipe_rotor_top;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 4;
    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel_req;
    logic [NR-1:0] sel_member;
    logic [NP-1:0] sel_pipe;
    logic          use_vld;
    logic [NR-1:0] use_member;
    logic [NP-1:0] use_pipe;
    logic          rel_vld;
    logic [NR-1:0] rel_member;
    logic [NP-1:0] rel_pipe;
    logic          ready;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_rotor_top #(.NUM_RES(NR), .NUM_PIPES(NP)) dut (
        .clk(clk), .rst(rst), .sel_req(sel_req), .sel_member(sel_member),
        .sel_pipe(sel_pipe), .use_vld(use_vld), .use_member(use_member),
        .use_pipe(use_pipe), .rel_vld(rel_vld), .rel_member(rel_member),
        .rel_pipe(rel_pipe), .ready(ready)
    );

    typedef struct packed {
        logic       sel;
        logic       u;
        logic [3:0] um;
        logic [1:0] up;
        logic       r;
        logic [3:0] rm;
        logic [1:0] rp;
        logic [3:0] em;
        logic [1:0] ep;
        logic       er;
        logic [7:0] req;
    } row_t;

    localparam int NROWS = 29;
    localparam row_t ROWS [NROWS] = '{
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b1000,2'b10,1'b1,8'd1},  // R1 first grant
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0100,2'b10,1'b1,8'd2},  // R2
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0010,2'b10,1'b1,8'd2},  // R2
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0001,2'b10,1'b1,8'd2},  // R2
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b1000,2'b01,1'b1,8'd2},  // R2 wrap
        '{1'b0,1'b1,4'b0100,2'b01,1'b0,4'b0000,2'b00,4'b0000,2'b00,1'b1,8'd5},  // R5 use
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0100,2'b10,1'b1,8'd3},  // R3 skip busy
        '{1'b0,1'b1,4'b0100,2'b10,1'b0,4'b0000,2'b00,4'b0000,2'b00,1'b1,8'd5},  // R5 drain m2
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0010,2'b01,1'b1,8'd6},  // R6
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0001,2'b01,1'b1,8'd6},  // R6
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b1000,2'b10,1'b1,8'd7},  // R7 m2 held out
        '{1'b0,1'b0,4'b0000,2'b00,1'b1,4'b0100,2'b01,4'b0000,2'b00,1'b1,8'd9},  // R9 release
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0010,2'b10,1'b1,8'd9},  // R9 not re-entered
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0001,2'b10,1'b1,8'd9},  // R9
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b1000,2'b01,1'b1,8'd7},  // R7
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0100,2'b01,1'b1,8'd7},  // R7 returns
        '{1'b0,1'b1,4'b0001,2'b10,1'b0,4'b0000,2'b00,4'b0000,2'b00,1'b1,8'd5},  // R5
        '{1'b0,1'b1,4'b0001,2'b01,1'b0,4'b0000,2'b00,4'b0000,2'b00,1'b1,8'd5},  // R5 drain m0
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0010,2'b01,1'b1,8'd8},  // R8
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b1000,2'b10,1'b1,8'd8},  // R8
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0100,2'b01,1'b1,8'd8},  // R8
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0010,2'b10,1'b1,8'd8},  // R8
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b1000,2'b01,1'b1,8'd8},  // R8 m0 stepped over
        '{1'b1,1'b0,4'b0000,2'b00,1'b1,4'b0001,2'b01,4'b0100,2'b01,1'b1,8'd10}, // R10 sel+rel
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0010,2'b01,1'b1,8'd10}, // R10
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0001,2'b01,1'b1,8'd10}, // R10 release seen
        '{1'b0,1'b1,4'b0001,2'b01,1'b1,4'b0100,2'b10,4'b0000,2'b00,1'b1,8'd10}, // R10 use+rel
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b1000,2'b10,1'b1,8'd10}, // R10
        '{1'b1,1'b0,4'b0000,2'b00,1'b0,4'b0000,2'b00,4'b0100,2'b10,1'b1,8'd10}  // R10 m2 pipe back
    };

    task automatic check(input string what, input int req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sel_req = 1'b0; use_vld = 1'b0; use_member = '0; use_pipe = '0;
        rel_vld = 1'b0; rel_member = '0; rel_pipe = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        do_reset();
        #1;
        check("reset ready", 1, int'(ready), 1);            // R1
        check("reset idle member", 5, int'(sel_member), 0); // R5
        check("reset idle pipe", 5, int'(sel_pipe), 0);     // R5

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            sel_req = ROWS[i].sel;
            use_vld = ROWS[i].u;   use_member = ROWS[i].um; use_pipe = ROWS[i].up;
            rel_vld = ROWS[i].r;   rel_member = ROWS[i].rm; rel_pipe = ROWS[i].rp;
            #1;
            check($sformatf("row %0d member", i), int'(ROWS[i].req), int'(sel_member), int'(ROWS[i].em));
            check($sformatf("row %0d pipe", i),   int'(ROWS[i].req), int'(sel_pipe),   int'(ROWS[i].ep));
            check($sformatf("row %0d ready", i),  int'(ROWS[i].req), int'(ready),      int'(ROWS[i].er));
        end

        // R4: drain every pipe, ready must fall; one release restores it.
        do_reset();
        for (int m = 0; m < NR; m++) begin
            for (int p = 0; p < NP; p++) begin
                @(negedge clk);
                idle_inputs();
                use_vld = 1'b1;
                use_member = NR'(1) << m;
                use_pipe   = NP'(1) << p;
            end
        end
        @(negedge clk);
        idle_inputs();
        #1;
        check("all busy ready", 4, int'(ready), 0);          // R4
        rel_vld = 1'b1; rel_member = 4'b0010; rel_pipe = 2'b10;
        @(negedge clk);
        idle_inputs();
        #1;
        check("one freed ready", 4, int'(ready), 1);         // R4
        sel_req = 1'b1;
        #1;
        check("freed member", 9, int'(sel_member), 4'b0010); // R9
        check("freed pipe", 3, int'(sel_pipe), 2'b10);       // R3
        @(negedge clk);
        idle_inputs();
        finish_run();
    end
endmodule